// File: doc/BRIEF.md
# Fractional Clock Divider with Accumulator Phase Control

This block derives a slower clock from a reference clock at a programmable fractional frequency ratio. A 12-bit ratio word L sets the long-term ratio of output frequency to input frequency to L/(4096 − L). Because every output period must last a whole number of input cycles, the divider switches between two neighbouring integer period lengths. The mix of short and long periods makes the average come out exactly at the programmed fraction. For example, an average divide of 4.5 is built from equal numbers of 4-cycle and 5-cycle periods.

Internally a phase accumulator with modulus M = 4096 − L adds L on every input cycle. Each time it wraps, a new output period begins. This is marked by a one-cycle tick, and the output clock goes high at the same point. A second, faster-stepping comparison ends the high phase after half of the current period, rounded down. Ratios above one half are not allowed: the word is limited to 1365. A ratio change is held back until the running period ends. A control input bypasses the divider, and the reference clock then goes straight to the output.

Top module: `frac_clk_div`

## Requirements
- R1: A ratio word above 1365 behaves exactly as 1365 (for example 2048 and 4095 give 1365 ticks in the R2 window with M = 2731).
- R2: With fractional mode on and ratio L in 1..1365 held from reset, let edge 0 be the first rising edge of `clk_i` with `rst_i` low. Exactly L ticks appear in the cycles following edges 2 through M+1, with M = 4096 − L.
- R3: Two consecutive ticks are N input cycles apart, where N is either floor(M/L) or ceil(M/L). N is never below 2.
- R4: In each output period, `clk_o` is high in the first floor(N/2) cycles, starting with the tick cycle, and low in the remaining cycles of the period.
- R5: `tick_o` is never high in two consecutive cycles in fractional mode, and `clk_o` is high in every cycle in which `tick_o` is high.
- R6: With ratio 0, `tick_o` stays low and `clk_o` stays low.
- R7: A new ratio word is taken only at a tick, so the period that is running when the word changes keeps the length set by the old ratio.
- R8: With `frac_en_i` low, `clk_o` equals `clk_i` and `tick_o` is held high. After returning to fractional mode, ticks resume from a cleared accumulator.
- R9: A synchronous reset clears the accumulator and drives `clk_o` and `tick_o` low. No tick is seen in the cycles following edges 0 and 1 after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference input clock |
| rst_i | input | 1 | Synchronous reset, active high |
| frac_en_i | input | 1 | 1 = fractional divider active, 0 = bypass (reference passed through) |
| ratio_i | input | 12 | Ratio word L; output/input frequency ratio is L/(4096 − L) |
| clk_o | output | 1 | Divided clock (or reference clock in bypass) |
| tick_o | output | 1 | One-cycle marker at the start of each output period |

## Verification
The bound checker watches, on every cycle, the invariants that hold regardless of stimulus: the latched ratio stays within its limit, the accumulator stays below its modulus, and ticks are isolated and coincide with a high output clock. It also checks that an idle divider never ticks and that the latched ratio only moves on a tick. The exact tick count over one full accumulator cycle, the split of each period into short and long lengths, and the high-phase duration are checked by the bench, which sweeps a wide set of ratio words and derives the expected values arithmetically. The bench also covers the deferred ratio change across a period boundary and the pass-through behaviour in bypass, since these depend on multi-period scenarios.

// File: rtl/frac_clk_pkg.sv
`timescale 1ns/1ps
package frac_clk_pkg;

    // Default ratio word width.
    localparam int FCD_W = 12;

    // Largest ratio word whose ratio L/(2**w - L) does not exceed one half.
    function automatic int fcd_limit(input int w);
        return (2 ** w) / 3;
    endfunction

endpackage

// File: rtl/fcd_ratio_clamp.sv
`timescale 1ns/1ps
module fcd_ratio_clamp #(
    parameter int W    = 12,
    parameter int LMAX = 1365
) (
    input  logic [W-1:0] ratio_i,
    output logic [W-1:0] ratio_o
);

    localparam logic [W-1:0] LIM = LMAX[W-1:0];

    // Words beyond the half-rate limit are pulled down to the limit.
    assign ratio_o = (ratio_i > LIM) ? LIM : ratio_i;

endmodule

// File: rtl/fcd_phase_step.sv
`timescale 1ns/1ps
module fcd_phase_step #(
    parameter int W = 12
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] lat_i,
    input  logic [W-1:0] nxt_i,
    output logic         fire_o,
    output logic [W-1:0] acc_o,
    output logic [W:0]   seed_o
);

    localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};

    logic [W:0] sum;
    logic [W:0] modv;

    always_comb begin
        sum    = {1'b0, acc_i} + {1'b0, lat_i};
        modv   = FULL - {1'b0, lat_i};
        fire_o = (sum >= modv);
        acc_o  = fire_o ? W'(sum - modv) : sum[W-1:0];
        // Shadow value for the first high-phase comparison of the next period.
        seed_o = {1'b0, acc_o} + {1'b0, nxt_i};
    end

endmodule

// File: rtl/fcd_duty_step.sv
`timescale 1ns/1ps
module fcd_duty_step #(
    parameter int W = 12
) (
    input  logic [W:0]   half_i,
    input  logic [W-1:0] lat_i,
    output logic         high_o,
    output logic [W:0]   half_o
);

    localparam logic [W+1:0] FULL2 = {2'b01, {W{1'b0}}};

    logic [W+1:0] ext;
    logic [W+1:0] step;
    logic [W+1:0] modv;

    // The shadow advances by 2L per cycle, so it crosses the modulus after
    // half as many cycles as the main accumulator.
    always_comb begin
        ext    = {1'b0, half_i};
        step   = ext + ({2'b00, lat_i} << 1);
        modv   = FULL2 - {2'b00, lat_i};
        high_o = (step < modv);
        half_o = (ext < modv) ? step[W:0] : half_i;
    end

endmodule

// File: rtl/frac_clk_div.sv
`timescale 1ns/1ps
module frac_clk_div #(
    parameter int W = frac_clk_pkg::FCD_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         frac_en_i,
    input  logic [W-1:0] ratio_i,
    output logic         clk_o,
    output logic         tick_o
);

    localparam int LMAX = frac_clk_pkg::fcd_limit(W);

    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] lat;
        logic [W:0]   half;
        logic         clk;
        logic         tick;
    } fcd_state_t;

    localparam fcd_state_t RST_STATE = '{acc: '0, lat: '0, half: '1, clk: 1'b0, tick: 1'b0};

    fcd_state_t state_d, state_q;

    logic [W-1:0] lim_ratio;
    logic         fire;
    logic [W-1:0] acc_step;
    logic [W:0]   seed;
    logic         high_step;
    logic [W:0]   half_step;

    // Observation points for the bound checker.
    logic [W-1:0] acc_q;
    logic [W-1:0] lat_q;
    assign acc_q = state_q.acc;
    assign lat_q = state_q.lat;

    fcd_ratio_clamp #(.W(W), .LMAX(LMAX)) i_clamp (
        .ratio_i (ratio_i),
        .ratio_o (lim_ratio)
    );

    fcd_phase_step #(.W(W)) i_phase (
        .acc_i  (state_q.acc),
        .lat_i  (state_q.lat),
        .nxt_i  (lim_ratio),
        .fire_o (fire),
        .acc_o  (acc_step),
        .seed_o (seed)
    );

    fcd_duty_step #(.W(W)) i_duty (
        .half_i (state_q.half),
        .lat_i  (state_q.lat),
        .high_o (high_step),
        .half_o (half_step)
    );

    always_comb begin
        state_d = state_q;
        if (!frac_en_i || state_q.lat == '0) begin
            // Bypass or idle: keep the phase cleared and follow the ratio word.
            state_d.acc  = '0;
            state_d.lat  = lim_ratio;
            state_d.half = '1;
            state_d.clk  = 1'b0;
            state_d.tick = 1'b0;
        end else begin
            state_d.acc  = acc_step;
            state_d.tick = fire && (lim_ratio != '0);
            if (fire) begin
                // Period boundary: the only point where a new ratio is adopted.
                state_d.lat  = lim_ratio;
                state_d.half = seed;
                state_d.clk  = (lim_ratio != '0);
            end else begin
                state_d.half = half_step;
                state_d.clk  = high_step;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= RST_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign clk_o  = frac_en_i ? state_q.clk  : clk_i;
    assign tick_o = frac_en_i ? state_q.tick : 1'b1;

endmodule

// File: rtl/frac_clk_div_chk.sv
`timescale 1ns/1ps
module frac_clk_div_chk #(
    parameter int W = 12
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         frac_en_i,
    input logic         tick_o,
    input logic         clk_o,
    input logic [W-1:0] acc_q,
    input logic [W-1:0] lat_q
);

    localparam int LMAX = frac_clk_pkg::fcd_limit(W);
    localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};

    p_clamp_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        lat_q <= LMAX[W-1:0]);

    p_acc_range_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        {1'b0, acc_q} < (FULL - {1'b0, lat_q}));

    p_single_tick_r5: assert property (@(posedge clk_i) disable iff (rst_i || !frac_en_i)
        tick_o |=> !tick_o);

    p_tick_high_r5: assert property (@(posedge clk_i) disable iff (rst_i || !frac_en_i)
        tick_o |-> clk_o);

    p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (rst_i || !frac_en_i)
        (lat_q == '0) |=> !tick_o);

    p_ratio_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i || !frac_en_i)
        ($past(frac_en_i) && ($past(lat_q) != '0) && (lat_q != $past(lat_q))) |-> tick_o);

endmodule

bind frac_clk_div frac_clk_div_chk #(.W(W)) i_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .frac_en_i (frac_en_i),
    .tick_o    (tick_o),
    .clk_o     (clk_o),
    .acc_q     (acc_q),
    .lat_q     (lat_q)
);

// File: tb/test_frac_clk_div.sv
`timescale 1ns/1ps
module test_frac_clk_div;

    localparam int W     = 12;
    localparam int FULLV = 4096;
    localparam int LIM   = 1365;

    logic         clk_i     = 1'b0;
    logic         rst_i     = 1'b1;
    logic         frac_en_i = 1'b1;
    logic [W-1:0] ratio_i   = '0;
    logic         clk_o;
    logic         tick_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk_i = ~clk_i;

    frac_clk_div #(.W(W)) i_frac_clk_div (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .frac_en_i (frac_en_i),
        .ratio_i   (ratio_i),
        .clk_o     (clk_o),
        .tick_o    (tick_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reset with the given word; returns at a falling edge with reset released.
    task automatic restart(input int word);
        rst_i     = 1'b1;
        frac_en_i = 1'b1;
        ratio_i   = W'(word);
        repeat (3) @(negedge clk_i);
        check(clk_o == 1'b0, "R9", "clk_o in reset", int'(clk_o), 0);
        check(tick_o == 1'b0, "R9", "tick_o in reset", int'(tick_o), 0);
        rst_i = 1'b0;
    endtask

    // Cycles until the next tick, counted from the current falling edge.
    task automatic gap(output int len);
        len = 0;
        do begin
            @(negedge clk_i);
            len++;
        end while (!tick_o && len < 10000);
    endtask

    task automatic sweep(input int word);
        int  eff;
        int  m;
        int  lo;
        int  hi;
        int  ticks;
        int  prev;
        int  hc;
        int  len;
        bit  last_tick;
        eff       = (word > LIM) ? LIM : word;
        m         = FULLV - eff;
        lo        = m / eff;
        hi        = (m + eff - 1) / eff;
        ticks     = 0;
        prev      = -1;
        hc        = 0;
        last_tick = 1'b0;
        restart(word);
        for (int n = 0; n <= m + 1; n++) begin
            @(negedge clk_i);
            if (n < 2) begin
                check(tick_o == 1'b0, "R9", "tick right after reset", int'(tick_o), 0);
            end else if (tick_o) begin
                ticks++;
            end
            if (tick_o) begin
                check(clk_o == 1'b1, "R5", "clk_o at tick", int'(clk_o), 1);
                check(!last_tick, "R5", "back-to-back tick", 1, 0);
                if (prev >= 0) begin
                    len = n - prev;
                    check(len == lo || len == hi, "R3", "period length", len, lo);
                    check(hc == len / 2, "R4", "high cycles", hc, len / 2);
                end
                prev = n;
                hc   = clk_o ? 1 : 0;
            end else begin
                hc += clk_o ? 1 : 0;
            end
            last_tick = tick_o;
        end
        if (word > LIM) begin
            check(ticks == eff, "R1", "ticks for clamped word", ticks, eff);
        end else begin
            check(ticks == eff, "R2", "ticks in one modulus", ticks, eff);
        end
    endtask

    initial begin
        int g;
        int ticks;
        int highs;

        // R2, R3, R4, R5 across a spread of words; R1 with oversized words.
        sweep(1);
        sweep(2);
        sweep(3);
        sweep(7);
        sweep(100);
        sweep(455);
        sweep(1000);
        sweep(1024);
        sweep(1364);
        sweep(1365);
        sweep(2048);
        sweep(4095);

        // R6: zero ratio stays silent.
        restart(0);
        ticks = 0;
        highs = 0;
        for (int n = 0; n < 300; n++) begin
            @(negedge clk_i);
            ticks += tick_o ? 1 : 0;
            highs += clk_o ? 1 : 0;
        end
        check(ticks == 0, "R6", "ticks with zero ratio", ticks, 0);
        check(highs == 0, "R6", "high cycles with zero ratio", highs, 0);

        // R7: change 1000 -> 500 right after a tick; running period keeps 3 or 4.
        restart(1000);
        gap(g);
        ratio_i = W'(500);
        gap(g);
        check(g == 3 || g == 4, "R7", "period after ratio change", g, 3);
        gap(g);
        gap(g);
        check(g == 7 || g == 8, "R7", "period under new ratio", g, 7);

        // R8: bypass passes the reference through and holds tick high.
        restart(100);
        repeat (20) @(negedge clk_i);
        frac_en_i = 1'b0;
        @(negedge clk_i);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk_i);
            #1;
            check(clk_o == 1'b1 && tick_o == 1'b1, "R8", "bypass high phase",
                  int'({clk_o, tick_o}), 3);
            @(negedge clk_i);
            #1;
            check(clk_o == 1'b0 && tick_o == 1'b1, "R8", "bypass low phase",
                  int'({clk_o, tick_o}), 1);
        end
        frac_en_i = 1'b1;
        // Cleared accumulator with L = 100, M = 3996: first crossing at 40 steps.
        gap(g);
        check(g >= 40 && g <= 42, "R8", "first period after bypass", g, 41);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule